// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This unit collects the event pulses of an SD/MMC host (command path, data path and card presence) into sticky status bits, combines the enabled ones into a single interrupt line, and lets software clear them one bit at a time by writing ones. It also reports live levels: write-protect, the two synchronised card-detect lines, and the command and data busy flags. It holds a small configuration byte. That byte picks where card presence comes from and which polarity means "present". It also holds a global interrupt enable and a CRC-abort flag for the data path.

Software reaches the unit over a byte-wide register bus. Writes take effect on the clock edge. Reads are combinational from the current address. The event sources drive one-cycle pulses. Card presence goes through a two-stage synchroniser into a two-state machine. The machine has the states `CD_ABSENT` and `CD_PRESENT`. The transition `ABSENT_TO_PRESENT` raises the inserted bit and the card-change bit. The transition `PRESENT_TO_ABSENT` raises only the card-change bit. While the state matches the corrected presence level, the machine stays where it is and emits nothing.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset every sticky status bit, both masks, the configuration byte and the clock-freeze bit read 0, and `irq` is low.
- R2: A one-cycle pulse on `ev_cmd[k]` sets bit k of status register 1 (address 1) at the next clock edge. The bit stays set until it is cleared. Status register 1 holds: bit 0 SDIO interrupt, 1 command done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error.
- R3: A write to status register 0 or 1 clears each sticky bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Level bits follow their inputs and ignore writes. In status register 0, bit 1 is `wp_level` with no delay, bit 2 is `card_dat3` and bit 3 is `card_pin`, both two clock edges after the input changes. In status register 2 (address 2), bit 4 is `busy_cmd` and bit 5 is `busy_data`.
- R6: `irq` is high exactly when the global enable (config bit 7) is set and some sticky bit is set together with its mask bit. Mask register 0 (address 4) enables status-0 bits 7..4 through its bits 7..4. Mask register 1 (address 5) enables status-1 bits 7..1 through its bits 7..1. Mask-1 bit 0 reads 0, so the SDIO bit never raises `irq`.
- R7: The card source is chosen by config bits. DAT3 is used when bit 6 is set. Otherwise the pin is used when bit 5 is set. With neither bit set, the card counts as absent. Config bit 4 set means a high level is "present"; clear means a low level is "present".
- R8: Going from absent to present sets status-0 bit 7 (inserted) and bit 6 (card change), three clock edges after the input changes. Going from present to absent sets only bit 6.
- R9: `ev_data_done[0]` sets status-0 bit 4 (multi-block done) and `ev_data_done[1]` sets status-0 bit 5 (block done). Both bits are sticky.
- R10: Status-2 bit 7 is a plain read/write bit that drives `clk_freeze_en`. Config bit 3 drives `crc_abort`.
- R11: Address map: 0..3 are status registers 0..3, 4 and 5 are the masks, 6 is the configuration byte (bits 2..0 read 0). Status register 3 and address 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wen | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ev_data_done | input | 2 | Data-path done pulses (0 multi-block, 1 block) |
| ev_cmd | input | 8 | Command/data event pulses, one per status-1 bit |
| wp_level | input | 1 | Write-protect level |
| busy_cmd | input | 1 | Command/response busy level |
| busy_data | input | 1 | Data busy level |
| card_pin | input | 1 | Card-detect pin, asynchronous |
| card_dat3 | input | 1 | DAT3 line used for card detect, asynchronous |
| irq | output | 1 | Combined interrupt |
| clk_freeze_en | output | 1 | Automatic clock-freeze enable |
| crc_abort | output | 1 | Abort transfer on CRC error |

## Verification
If a sticky bit is lost or set by mistake, it shows up on the next read of its status register, and on `irq` one cycle after the faulty edge whenever that bit is enabled. A presence machine stuck in the wrong state shows up as a missing or extra inserted/change bit exactly three edges after a card input moves. A one-cycle slip in the synchroniser moves that edge, so the bench samples the cycle before and the cycle of the expected change. A wrong source or polarity choice shows up when the non-selected line is moved and a change bit appears anyway.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int unsigned REG_AW = 3;
    localparam int unsigned REG_DW = 8;

    localparam logic [REG_AW-1:0] ADR_STS0 = 3'd0;
    localparam logic [REG_AW-1:0] ADR_STS1 = 3'd1;
    localparam logic [REG_AW-1:0] ADR_STS2 = 3'd2;
    localparam logic [REG_AW-1:0] ADR_STS3 = 3'd3;
    localparam logic [REG_AW-1:0] ADR_MSK0 = 3'd4;
    localparam logic [REG_AW-1:0] ADR_MSK1 = 3'd5;
    localparam logic [REG_AW-1:0] ADR_CFG  = 3'd6;

    // configuration byte bit positions
    localparam int unsigned CFG_GLB_EN  = 7;
    localparam int unsigned CFG_SRC_D3  = 6;
    localparam int unsigned CFG_SRC_PIN = 5;
    localparam int unsigned CFG_POL_HI  = 4;
    localparam int unsigned CFG_CRC_AB  = 3;

    typedef enum logic [0:0] {
        CD_ABSENT  = 1'b0,
        CD_PRESENT = 1'b1
    } cd_state_e;
endpackage

// File: rtl/sdh_sync.sv
module sdh_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdh_sticky.sv
module sdh_sticky #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic bit_q;

        // a set event has priority over a write-1 clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_i[b]) begin
                bit_q <= 1'b1;
            end else if (clr_i[b]) begin
                bit_q <= 1'b0;
            end
        end

        assign q_o[b] = bit_q;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> q_o[b]); // R4

        AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[b] && !clr_i[b]) |=> q_o[b]); // R2
    end
endmodule

// File: rtl/sdh_cd_detect.sv
module sdh_cd_detect
    import sdh_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic dat3_s,
    input  logic sel_pin,
    input  logic sel_dat3,
    input  logic pol_hi,
    output logic insert_p,
    output logic change_p
);
    cd_state_e state_q;
    cd_state_e state_d;
    logic      raw_sel;
    logic      present;

    // source selection: DAT3 has priority, no source means absent
    always_comb begin
        raw_sel = 1'b0;
        if (sel_dat3) begin
            raw_sel = dat3_s;
        end else if (sel_pin) begin
            raw_sel = pin_s;
        end
        present = (sel_dat3 || sel_pin) && (pol_hi ? raw_sel : !raw_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CD_ABSENT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        insert_p = 1'b0;
        change_p = 1'b0;
        unique case (state_q)
            CD_ABSENT: begin
                if (present) begin
                    state_d  = CD_PRESENT;
                    insert_p = 1'b1;
                    change_p = 1'b1;
                end
            end
            CD_PRESENT: begin
                if (!present) begin
                    state_d  = CD_ABSENT;
                    change_p = 1'b1;
                end
            end
        endcase
    end

    AST_INSERT_ENTERS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        insert_p |=> (state_q == CD_PRESENT)); // R8

    AST_CHANGE_MOVES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        change_p |=> (state_q != $past(state_q))); // R8
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic [1:0]        ev_data_done,
    input  logic [7:0]        ev_cmd,
    input  logic              wp_level,
    input  logic              busy_cmd,
    input  logic              busy_data,
    input  logic              card_pin,
    input  logic              card_dat3,
    output logic              irq,
    output logic              clk_freeze_en,
    output logic              crc_abort
);
    localparam int unsigned S0_W = 4;  // sticky bits 7..4 of status 0
    localparam int unsigned S1_W = 8;  // sticky bits 7..0 of status 1

    logic [S0_W-1:0] s0_q, s0_set, s0_clr;
    logic [S1_W-1:0] s1_q, s1_clr;
    logic [S0_W-1:0] msk0_q;   // enables status-0 bits 7..4
    logic [S1_W-1:1] msk1_q;   // enables status-1 bits 7..1
    logic [7:3]      cfg_q;
    logic            freeze_q;
    logic [1:0]      cd_sync;  // {dat3, pin}
    logic            insert_p, change_p;
    logic            wr_s0, wr_s1, wr_s2, wr_m0, wr_m1, wr_cfg;

    assign wr_s0  = bus_wen && (bus_addr == ADR_STS0);
    assign wr_s1  = bus_wen && (bus_addr == ADR_STS1);
    assign wr_s2  = bus_wen && (bus_addr == ADR_STS2);
    assign wr_m0  = bus_wen && (bus_addr == ADR_MSK0);
    assign wr_m1  = bus_wen && (bus_addr == ADR_MSK1);
    assign wr_cfg = bus_wen && (bus_addr == ADR_CFG);

    sdh_sync #(.W(2), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({card_dat3, card_pin}),
        .sync_o  (cd_sync)
    );

    sdh_cd_detect i_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (cd_sync[0]),
        .dat3_s   (cd_sync[1]),
        .sel_pin  (cfg_q[CFG_SRC_PIN]),
        .sel_dat3 (cfg_q[CFG_SRC_D3]),
        .pol_hi   (cfg_q[CFG_POL_HI]),
        .insert_p (insert_p),
        .change_p (change_p)
    );

    assign s0_set = {insert_p, change_p, ev_data_done[1], ev_data_done[0]};
    assign s0_clr = wr_s0 ? bus_wdata[7:4] : '0;
    assign s1_clr = wr_s1 ? bus_wdata : '0;

    sdh_sticky #(.W(S0_W)) i_sts0 (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (s0_set),
        .clr_i (s0_clr),
        .q_o   (s0_q)
    );

    sdh_sticky #(.W(S1_W)) i_sts1 (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_cmd),
        .clr_i (s1_clr),
        .q_o   (s1_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk0_q   <= '0;
            msk1_q   <= '0;
            cfg_q    <= '0;
            freeze_q <= 1'b0;
        end else begin
            if (wr_m0)  msk0_q   <= bus_wdata[7:4];
            if (wr_m1)  msk1_q   <= bus_wdata[7:1];
            if (wr_cfg) cfg_q    <= bus_wdata[7:3];
            if (wr_s2)  freeze_q <= bus_wdata[7];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_STS0: bus_rdata = {s0_q, cd_sync[0], cd_sync[1], wp_level, 1'b0};
            ADR_STS1: bus_rdata = s1_q;
            ADR_STS2: bus_rdata = {freeze_q, 1'b0, busy_data, busy_cmd, 4'b0};
            ADR_STS3: bus_rdata = '0;
            ADR_MSK0: bus_rdata = {msk0_q, 4'b0};
            ADR_MSK1: bus_rdata = {msk1_q, 1'b0};
            ADR_CFG:  bus_rdata = {cfg_q, 3'b0};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = cfg_q[CFG_GLB_EN] &&
                 ((|(s0_q & msk0_q)) || (|(s1_q[7:1] & msk1_q)));
    assign clk_freeze_en = freeze_q;
    assign crc_abort     = cfg_q[CFG_CRC_AB];

    AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_q[CFG_GLB_EN]); // R6

    AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s1 && (bus_wdata == 8'hFF) && (ev_cmd == 8'h00)) |=> (s1_q == 8'h00)); // R3

    AST_SDIO_ONLY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((s1_q == 8'h01) && ((s0_q & msk0_q) == '0)) |-> !irq); // R6
endmodule

// File: tb/test_sdh_irq_status.sv
module test_sdh_irq_status;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wen = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ev_data_done = '0;
    logic [7:0] ev_cmd = '0;
    logic       wp_level = 1'b0;
    logic       busy_cmd = 1'b0;
    logic       busy_data = 1'b0;
    logic       card_pin = 1'b1;
    logic       card_dat3 = 1'b0;
    logic       irq, clk_freeze_en, crc_abort;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdh_irq_status i_sdh_irq_status (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_data_done(ev_data_done), .ev_cmd(ev_cmd),
        .wp_level(wp_level), .busy_cmd(busy_cmd), .busy_data(busy_data),
        .card_pin(card_pin), .card_dat3(card_dat3),
        .irq(irq), .clk_freeze_en(clk_freeze_en), .crc_abort(crc_abort)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_cmd(input logic [7:0] bits);
        @(negedge clk);
        ev_cmd = bits;
        @(negedge clk);
        ev_cmd = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd0, v); check("R1 sts0", v, 8'h00);
        rd(3'd1, v); check("R1 sts1", v, 8'h00);
        rd(3'd2, v); check("R1 sts2", v, 8'h00);
        rd(3'd4, v); check("R1 msk0", v, 8'h00);
        rd(3'd5, v); check("R1 msk1", v, 8'h00);
        rd(3'd6, v); check("R1 cfg", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 freeze", {7'b0, clk_freeze_en}, 8'h00);
    endtask

    task automatic t_levels();
        logic [7:0] v;
        @(negedge clk);
        wp_level = 1'b1;
        rd(3'd0, v); check("R5 wp level", v & 8'h02, 8'h02);
        wr(3'd0, 8'hFF);
        rd(3'd0, v); check("R5 wp ignores write", v & 8'h02, 8'h02);
        wp_level = 1'b0;
        busy_cmd = 1'b1;
        wr(3'd2, 8'h30);
        rd(3'd2, v); check("R5 busy cmd, write ignored", v, 8'h10);
        busy_cmd = 1'b0; busy_data = 1'b1;
        rd(3'd2, v); check("R5 busy data", v, 8'h20);
        busy_data = 1'b0;
        @(negedge clk);
        card_dat3 = 1'b1;
        @(negedge clk);
        rd(3'd0, v); check("R5 dat3 after one edge", v & 8'h04, 8'h00);
        @(negedge clk);
        rd(3'd0, v); check("R5 dat3 after two edges", v & 8'h04, 8'h04);
        card_dat3 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_events();
        logic [7:0] v;
        pulse_cmd(8'h81);
        rd(3'd1, v); check("R2 set from pulse", v, 8'h81);
        pulse_cmd(8'h20);
        rd(3'd1, v); check("R2 sticky accumulate", v, 8'hA1);
        wr(3'd1, 8'h01);
        rd(3'd1, v); check("R3 partial clear", v, 8'hA0);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check("R3 full clear", v, 8'h00);
        @(negedge clk); ev_data_done = 2'b01;
        @(negedge clk); ev_data_done = 2'b00;
        rd(3'd0, v); check("R9 multi-block done", v & 8'hF0, 8'h10);
        @(negedge clk); ev_data_done = 2'b10;
        @(negedge clk); ev_data_done = 2'b00;
        rd(3'd0, v); check("R9 block done", v & 8'hF0, 8'h30);
        wr(3'd0, 8'h10);
        rd(3'd0, v); check("R3 status0 clear", v & 8'hF0, 8'h20);
        wr(3'd0, 8'hFF);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        pulse_cmd(8'h0A);
        @(negedge clk);
        ev_cmd = 8'h04; bus_addr = 3'd1; bus_wdata = 8'hFF; bus_wen = 1'b1;
        @(negedge clk);
        ev_cmd = 8'h00; bus_wen = 1'b0;
        rd(3'd1, v); check("R4 set beats clear", v, 8'h04);
        wr(3'd1, 8'hFF);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(3'd5, 8'h04);
        pulse_cmd(8'h04);
        check("R6 irq blocked by global", {7'b0, irq}, 8'h00);
        wr(3'd6, 8'h80);
        check("R6 irq enabled", {7'b0, irq}, 8'h01);
        wr(3'd5, 8'h00);
        check("R6 irq masked", {7'b0, irq}, 8'h00);
        wr(3'd5, 8'hFF);
        rd(3'd5, v); check("R6 mask1 bit0 reads 0", v, 8'hFE);
        check("R6 irq via mask1", {7'b0, irq}, 8'h01);
        wr(3'd1, 8'hFF);
        pulse_cmd(8'h01);
        check("R6 sdio never irq", {7'b0, irq}, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'hF0);
        rd(3'd4, v); check("R6 mask0 readback", v, 8'hF0);
        wr(3'd4, 8'h00);
        wr(3'd6, 8'h00);
    endtask

    task automatic t_card();
        logic [7:0] v;
        wr(3'd6, 8'hA0);
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'h80);
        rd(3'd0, v); check("R8 no event, pin idle high", v & 8'hC0, 8'h00);
        card_pin = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, v); check("R8 not yet inserted", v & 8'hC0, 8'h00);
        check("R5 pin level low", v & 8'h08, 8'h00);
        @(negedge clk);
        rd(3'd0, v); check("R8 inserted and change", v & 8'hC0, 8'hC0);
        check("R8 irq on insert", {7'b0, irq}, 8'h01);
        wr(3'd0, 8'hFF);
        check("R8 irq cleared", {7'b0, irq}, 8'h00);
        card_pin = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R8 removal change only", v & 8'hC0, 8'h40);
        wr(3'd0, 8'hFF);
        wr(3'd6, 8'hF0);
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R7 dat3 has priority over pin", v & 8'hC0, 8'h00);
        card_dat3 = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R7 dat3 active-high insert", v & 8'hC0, 8'hC0);
        wr(3'd0, 8'hFF);
        wr(3'd6, 8'h80);
        @(negedge clk);
        rd(3'd0, v); check("R7 no source means absent", v & 8'hC0, 8'h40);
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_config();
        logic [7:0] v;
        wr(3'd6, 8'hFF);
        rd(3'd6, v); check("R11 cfg low bits read 0", v, 8'hF8);
        check("R10 crc abort", {7'b0, crc_abort}, 8'h01);
        busy_cmd = 1'b1; busy_data = 1'b1;
        wr(3'd2, 8'h80);
        rd(3'd2, v); check("R10 freeze bit with busy", v, 8'hB0);
        check("R10 freeze output", {7'b0, clk_freeze_en}, 8'h01);
        rd(3'd3, v); check("R11 status3 reads 0", v, 8'h00);
        rd(3'd7, v); check("R11 addr7 reads 0", v, 8'h00);
        wr(3'd2, 8'h00);
        check("R10 freeze off", {7'b0, clk_freeze_en}, 8'h00);
        wr(3'd6, 8'h00);
        check("R10 crc abort off", {7'b0, crc_abort}, 8'h00);
        busy_cmd = 1'b0; busy_data = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_levels();
        t_events();
        t_set_wins();
        t_irq();
        t_card();
        t_config();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule